// File: doc/BRIEF.md
# Serial Configuration Stream Read Port

This block is the read side of a bit-serial memory that holds a configuration image for a master device. The master drives the clock, an active-low chip enable and one combined control pin. On each clock edge the block moves through its stored image one bit at a time and puts the bit at the current address on a serial output. That output has a separate drive enable, so it can feed a three-state pad.

The combined control pin does two jobs. In one state it clears the bit address counter and releases the output. In the other state it lets the block count and drive. A build parameter picks which pin level means which. A stream-select input must be high for normal reads. When it is low, the block is in programming mode. In that mode the output is released, the counter holds, and a parallel word port can load the internal array. When the chip enable is high, counting stops and the block reports standby.

Top module: `cfgstream_rd`

## Requirements
- R1: After the synchronous reset `rst`, the bit address is zero. The first stream cycle presents bit 0 of word 0, and `eos` is low.
- R2: On every rising clock edge where `ce_n` is 0, `gate_ctl` is in its enable state and `stream_sel` is 1, the bit address advances by one. After that edge, `sdo_bit` presents the bit at the new address.
- R3: On any edge where `gate_ctl` is in its clear state, the address goes to zero, whatever `ce_n` is. `sdo_en` is 0 while the pin is in the clear state.
- R4: While `ce_n` is 1 and `stream_sel` is 1, the address holds, `sdo_en` is 0 and `standby` is 1.
- R5: `sdo_en` is 1 only when `ce_n` is 0, `gate_ctl` is in its enable state and `stream_sel` is 1. Whenever `sdo_en` is 0, `sdo_bit` is 0.
- R6: With `CLR_ACTIVE_LOW`=1 (the default), `gate_ctl`=0 is the clear state and 1 is the enable state. With `CLR_ACTIVE_LOW`=0 the meanings are swapped.
- R7: An advance from the last address (DEPTH-1) wraps the address to 0. `eos` is then 1 for exactly the one cycle after that edge.
- R8: While `stream_sel` is 0, the address holds, `sdo_en` is 0 and `standby` is 0 whatever `ce_n` is. A write with `wr_en`=1 stores `wr_data` at word `wr_word`. A write while `stream_sel` is 1 is ignored.
- R9: Stream address a maps to word a / WORD_W. With `MSB_FIRST`=1 (the default) it reads bit WORD_W-1-(a mod WORD_W) of that word, so the most significant bit of each word comes out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock from the master |
| rst | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Active-low chip enable |
| gate_ctl | input | 1 | Combined counter-clear / output-enable pin, polarity set by CLR_ACTIVE_LOW |
| stream_sel | input | 1 | 1 selects stream reads, 0 selects programming mode |
| wr_en | input | 1 | Array word write strobe (programming mode only) |
| wr_word | input | $clog2(DEPTH/WORD_W) | Word address of the write |
| wr_data | input | WORD_W | Word to store |
| sdo_en | output | 1 | Drive enable for the serial data pad |
| sdo_bit | output | 1 | Serial data bit, 0 when not driven |
| standby | output | 1 | High while the chip enable holds the block idle |
| eos | output | 1 | One-cycle pulse after the address wraps to zero |

## Verification
The assertions assume that all control inputs change only away from the rising clock edge. They also assume `wr_en` is raised only for single cycles. The bench drives every input at the falling edge and samples half a phase after the rising edge. It also checks once between the falling edge and the next rising edge, so both the pre-edge and post-edge bit are seen. A second instance with the opposite pin polarity gets the inverted control pin, so both instances must give the same outputs.

// File: rtl/cfgstream_pkg.sv
package cfgstream_pkg;

    typedef struct packed {
        logic clr;      // counter clear requested by the combined pin
        logic adv;      // advance the bit address this edge
        logic drive;    // serial pad driven
        logic standby;  // chip enable holds the block idle
        logic prog;     // programming mode active
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic ce_n, input logic gate,
                                        input logic sel, input bit clr_low);
        ctl_t c;
        logic in_clr;
        in_clr    = clr_low ? ~gate : gate;
        c.clr     = in_clr;
        c.prog    = ~sel;
        c.adv     = sel & ~ce_n & ~in_clr;
        c.drive   = sel & ~ce_n & ~in_clr;
        c.standby = sel & ce_n;
        return c;
    endfunction

endpackage

// File: rtl/cfgstream_ctl.sv
module cfgstream_ctl
    import cfgstream_pkg::*;
#(
    parameter bit CLR_ACTIVE_LOW = 1'b1
) (
    input  logic ce_n,
    input  logic gate_ctl,
    input  logic stream_sel,
    output ctl_t ctl
);
    always_comb begin
        ctl = decode_ctl(ce_n, gate_ctl, stream_sel, CLR_ACTIVE_LOW);
    end
endmodule

// File: rtl/cfgstream_ctr.sv
module cfgstream_ctr #(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              eos
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr <= '0;
            eos  <= 1'b0;
        end else if (adv) begin
            if (addr == LAST) begin
                addr <= '0;
                eos  <= 1'b1;
            end else begin
                addr <= addr + 1'b1;
                eos  <= 1'b0;
            end
        end else begin
            eos <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgstream_mem.sv
module cfgstream_mem #(
    parameter int DEPTH     = 256,
    parameter int WORD_W    = 8,
    parameter bit MSB_FIRST = 1'b1,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int WORDS    = DEPTH / WORD_W,
    localparam int WADDR_W  = $clog2(WORDS),
    localparam int BSEL_W   = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               wr_ok,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_word,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_bit
);
    logic [WORD_W-1:0] store [WORDS];
    logic [WORD_W-1:0] rd_word;
    logic [BSEL_W-1:0] bsel;

    always_ff @(posedge clk) begin
        if (wr_ok && wr_en) begin
            store[wr_word] <= wr_data;
        end
    end

    assign rd_word = store[rd_addr[ADDR_W-1:BSEL_W]];

    generate
        if (MSB_FIRST) begin : g_msb
            assign bsel = BSEL_W'(WORD_W - 1) - rd_addr[BSEL_W-1:0];
        end else begin : g_lsb
            assign bsel = rd_addr[BSEL_W-1:0];
        end
    endgenerate

    assign rd_bit = rd_word[bsel];
endmodule

// File: rtl/cfgstream_rd.sv
module cfgstream_rd
    import cfgstream_pkg::*;
#(
    parameter int DEPTH          = 256,
    parameter int WORD_W         = 8,
    parameter bit CLR_ACTIVE_LOW = 1'b1,
    parameter bit MSB_FIRST      = 1'b1,
    localparam int ADDR_W        = $clog2(DEPTH),
    localparam int WADDR_W       = $clog2(DEPTH / WORD_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               gate_ctl,
    input  logic               stream_sel,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_word,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               sdo_en,
    output logic               sdo_bit,
    output logic               standby,
    output logic               eos
);
    ctl_t              ctl;
    logic [ADDR_W-1:0] cnt_q;
    logic              rd_bit;

    cfgstream_ctl #(.CLR_ACTIVE_LOW(CLR_ACTIVE_LOW)) u_ctl (
        .ce_n(ce_n), .gate_ctl(gate_ctl), .stream_sel(stream_sel), .ctl(ctl)
    );

    cfgstream_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk(clk), .rst(rst), .clr(ctl.clr), .adv(ctl.adv),
        .addr(cnt_q), .eos(eos)
    );

    cfgstream_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_mem (
        .clk(clk), .wr_ok(ctl.prog), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .rd_addr(cnt_q), .rd_bit(rd_bit)
    );

    assign sdo_en  = ctl.drive;
    assign sdo_bit = ctl.drive & rd_bit;
    assign standby = ctl.standby;
endmodule

// File: rtl/cfgstream_chk.sv
module cfgstream_chk #(
    parameter bit CLR_ACTIVE_LOW = 1'b1,
    parameter int ADDR_W         = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              gate_ctl,
    input logic              stream_sel,
    input logic              sdo_en,
    input logic              sdo_bit,
    input logic              eos,
    input logic [ADDR_W-1:0] cnt
);
    logic pin_clr;
    assign pin_clr = CLR_ACTIVE_LOW ? ~gate_ctl : gate_ctl;

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && stream_sel && !pin_clr && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        pin_clr |=> (cnt == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && stream_sel && !pin_clr) |=> $stable(cnt));

    // R5
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> (!ce_n && stream_sel && !pin_clr));

    // R5
    quiet_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo_bit);

    // R7
    wrap_mark_chk: assert property (@(posedge clk) disable iff (rst)
        eos |-> (cnt == '0));

    // R8
    prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stream_sel && !pin_clr) |=> $stable(cnt));
endmodule

bind cfgstream_rd cfgstream_chk #(.CLR_ACTIVE_LOW(CLR_ACTIVE_LOW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .gate_ctl(gate_ctl), .stream_sel(stream_sel),
    .sdo_en(sdo_en), .sdo_bit(sdo_bit), .eos(eos), .cnt(cnt_q)
);

// File: tb/cfgstream_rd_tb.sv
`timescale 1ns/1ps
module cfgstream_rd_tb;
    localparam int DEPTH = 256;
    localparam int WW    = 8;
    localparam int WORDS = DEPTH / WW;

    typedef struct {
        logic [3:0] exp;   // {sdo_en, sdo_bit, standby, eos}
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, gate = 1'b1, gate_inv = 1'b0, sel = 1'b1;
    logic wr_en = 1'b0;
    logic [4:0] wr_word = '0;
    logic [7:0] wr_data = '0;
    logic en_a, bit_a, sb_a, eos_a, en_b, bit_b, sb_b, eos_b;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    item_t q[$];
    logic [7:0] mm [WORDS];
    int m_addr = 0;

    always #10 clk = ~clk;

    cfgstream_rd u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .gate_ctl(gate), .stream_sel(sel),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .sdo_en(en_a), .sdo_bit(bit_a), .standby(sb_a), .eos(eos_a)
    );

    // R6: opposite polarity, fed the inverted pin
    cfgstream_rd #(.CLR_ACTIVE_LOW(1'b0)) u_dut_inv (
        .clk(clk), .rst(rst), .ce_n(ce_n), .gate_ctl(gate_inv), .stream_sel(sel),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .sdo_en(en_b), .sdo_bit(bit_b), .standby(sb_b), .eos(eos_b)
    );

    // R9: MSB of each word first
    function automatic logic bit_at(int a);
        return mm[a / WW][WW - 1 - (a % WW)];
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (en,bit,stby,eos)", tag, act, exp);
        end
    endtask

    logic last_eos = 1'b0;

    task automatic cyc(logic c, logic g, logic s, string tag);
        item_t it;
        logic en;
        logic e = 1'b0;
        @(negedge clk);
        ce_n = c; gate = g; gate_inv = ~g; sel = s;
        #2;
        en = s & ~c & g;
        check({tag, " pre"}, {en_a, bit_a, sb_a, eos_a}, {en, en & bit_at(m_addr), c & s, last_eos});
        check({tag, " pre R6"}, {en_b, bit_b, sb_b, eos_b}, {en, en & bit_at(m_addr), c & s, last_eos});
        if (!g) m_addr = 0;
        else if (s && !c) begin
            e = (m_addr == DEPTH - 1);
            m_addr = (m_addr + 1) % DEPTH;
        end
        last_eos = e;
        it.exp = {en, en & bit_at(m_addr), c & s, e};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(int w, logic [7:0] d, logic s);
        @(negedge clk);
        ce_n = 1'b1; gate = 1'b1; gate_inv = 1'b0; sel = s;
        wr_en = 1'b1; wr_word = 5'(w); wr_data = d;
        if (!s) mm[w] = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        last_eos = 1'b0;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                check(it.tag, {en_a, bit_a, sb_a, eos_a}, it.exp);
                check({it.tag, " R6"}, {en_b, bit_b, sb_b, eos_b}, it.exp);
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, "R1 R4 idle after reset");
        for (int w = 0; w < WORDS; w++) wr(w, 8'(w * 29 + 3) ^ 8'h5A, 1'b0);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R8 prog mode");
        cyc(1'b1, 1'b1, 1'b0, "R8 prog ce high");
        wr(0, ~mm[0], 1'b1);  // R8: ignored, stream below shows old word 0
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b1, "R1 R2 R9 stream");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, "R4 frozen");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, "R2 resume");
        cyc(1'b1, 1'b0, 1'b1, "R3 clear ce high");
        cyc(1'b0, 1'b1, 1'b1, "R3 restart");
        cyc(1'b0, 1'b0, 1'b1, "R3 clear ce low");
        for (int i = 0; i < DEPTH + 4; i++) cyc(1'b0, 1'b1, 1'b1, "R7 R9 wrap");
        cyc(1'b0, 1'b1, 1'b0, "R8 hold mid stream");
        cyc(1'b0, 1'b1, 1'b1, "R2 after prog");
        @(negedge clk);
        sel = 1'b0;
        repeat (2) @(posedge clk);
        #6;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule